// File: doc/BRIEF.md
# Paired-Half Stack Pointer Unit

This block computes the next value of a stack pointer kept in an accumulator, for three stack operations: push, pop and adjust. The pointer is a word made of two equal halves. In the short format the upper half is a signed count of free or used slots and the lower half is an address; both halves move together on every operation, with no carry passing from the lower half into the upper one. In the long format the whole word is one address and moves as a single number.

For each accepted operation the unit returns the updated pointer, the memory address the operation touches (the new address for a push, the old address for a pop, none for an adjust), read and write strobes, and a trap flag that reports stack overflow or underflow. In the short format the trap comes from the count half: a carry condition for push and pop, a sign transition for adjust, where the sign of the adjustment picks which transition counts. The long format never traps. Results appear one clock after the operation is presented. Memory data and the jump targets of call and return are handled elsewhere.

Top module: `paired_sp_unit`

## Requirements
- R1: An operation is accepted when `op_valid` is 1 and `op` is not 2'b00 (op codes: 2'b00 none, 2'b01 push, 2'b10 pop, 2'b11 adjust). One clock after acceptance `res_valid` is 1 for one cycle with the result; with `op_valid` 0 or `op` 2'b00, `res_valid`, `mem_rd`, `mem_wr` and `trap` are 0 in the next cycle.
- R2: Short-format push (`long_fmt` 0) adds 1 to the upper half and 1 to the lower half, each wrapping within its own 18 bits; `mem_wr` is 1 and `mem_addr` is the new lower half, zero-extended to the word.
- R3: Short-format push sets `trap` exactly when the upper half was all ones before the push (carry out of the count half).
- R4: Short-format pop subtracts 1 from each half independently; `mem_rd` is 1 and `mem_addr` is the old lower half, zero-extended.
- R5: Short-format pop sets `trap` exactly when the upper half was zero before the pop (no carry out when adding all ones).
- R6: Short-format adjust adds the 18-bit `adj` to each half independently, no carry between halves; `mem_rd`, `mem_wr` are 0 and `mem_addr` is 0.
- R7: Short-format adjust traps by the sign of `adj` (bit 17): with bit 17 clear, trap when the old upper half had bit 17 set and the new one has it clear; with bit 17 set, trap when the old upper half had bit 17 clear and the new one has it set.
- R8: Long format (`long_fmt` 1): push adds 1 to the whole word and writes to the new word; pop reads from the old word and subtracts 1; adjust adds `adj` sign-extended to 36 bits; `trap` is always 0.
- R9: `trap` is a one-cycle pulse that only appears together with `res_valid`; after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 2 | Operation code: 00 none, 01 push, 10 pop, 11 adjust |
| long_fmt | input | 1 | 1 selects the whole-word pointer format |
| ptr_in | input | 36 | Current pointer value |
| adj | input | 18 | Signed adjustment for adjust operations |
| res_valid | output | 1 | Result present |
| ptr_out | output | 36 | Updated pointer |
| mem_addr | output | 36 | Address the operation touches |
| mem_rd | output | 1 | Pop reads memory at `mem_addr` |
| mem_wr | output | 1 | Push writes memory at `mem_addr` |
| trap | output | 1 | Stack overflow or underflow |

## Verification
The bench builds the unit with its defaults, 18-bit halves and the registered output stage, so every value it checks is the real word width and each result lands exactly one cycle after its operation. With full-width halves the bench can set up the all-ones and zero count halves, the lower-half wrap that must not touch the count, and the sign crossings of the count half under adjustments of both signs. The long-format cases cover a carry that crosses the half boundary and full-word wrap, which must never trap.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [1:0] {
      SP_NONE = 2'b00,
      SP_PUSH = 2'b01,
      SP_POP  = 2'b10,
      SP_ADJ  = 2'b11
   } sp_op_e;
endpackage

// File: rtl/sp_half_adder.sv
module sp_half_adder #(
   parameter int W = 18
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (W < 1) begin : g_bad_w
         $error("sp_half_adder: W must be at least 1");
      end
   endgenerate

   logic [W:0] wide;
   always_comb begin
      wide = {1'b0, a} + {1'b0, b};
   end
   assign sum  = wide[W-1:0];
   assign cout = wide[W];
endmodule

// File: rtl/sp_trap_eval.sv
module sp_trap_eval
   import sp_pkg::*;
(
   input  sp_op_e op,
   input  logic   long_fmt,
   input  logic   step_neg,
   input  logic   cnt_old_neg,
   input  logic   cnt_new_neg,
   input  logic   cnt_cout,
   output logic   trap
);
   always_comb begin
      trap = 1'b0;
      if (!long_fmt) begin
         unique case (op)
            SP_PUSH: trap = cnt_cout;
            SP_POP:  trap = !cnt_cout;
            SP_ADJ:  trap = step_neg ? (!cnt_old_neg && cnt_new_neg)
                                     : (cnt_old_neg && !cnt_new_neg);
            default: trap = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/sp_next_ptr.sv
module sp_next_ptr
   import sp_pkg::*;
#(
   parameter int HALF_W = 18,
   localparam int WORD_W = 2 * HALF_W
) (
   input  sp_op_e              op,
   input  logic                long_fmt,
   input  logic [WORD_W-1:0]   ptr,
   input  logic [HALF_W-1:0]   adj,
   output logic [WORD_W-1:0]   nxt,
   output logic [WORD_W-1:0]   addr,
   output logic                rd,
   output logic                wr,
   output logic                trap
);
   localparam int NHALF = 2;

   logic [HALF_W-1:0] step;
   logic [WORD_W-1:0] step_wide;
   logic [HALF_W-1:0] half_sum  [NHALF];
   logic              half_cout [NHALF];
   logic [WORD_W-1:0] word_sum;
   logic              word_cout;
   logic [WORD_W-1:0] short_nxt;

   always_comb begin
      unique case (op)
         SP_PUSH: step = HALF_W'(1);
         SP_POP:  step = '1;
         default: step = adj;
      endcase
      step_wide = {{HALF_W{step[HALF_W-1]}}, step};
   end

   // Index 0 is the address half, index 1 the count half.
   for (genvar h = 0; h < NHALF; h++) begin : g_half
      sp_half_adder #(.W(HALF_W)) u_add (
         .a    (ptr[h*HALF_W +: HALF_W]),
         .b    (step),
         .sum  (half_sum[h]),
         .cout (half_cout[h])
      );
      assign short_nxt[h*HALF_W +: HALF_W] = half_sum[h];
   end

   sp_half_adder #(.W(WORD_W)) u_word (
      .a    (ptr),
      .b    (step_wide),
      .sum  (word_sum),
      .cout (word_cout)
   );

   sp_trap_eval u_trap (
      .op          (op),
      .long_fmt    (long_fmt),
      .step_neg    (step[HALF_W-1]),
      .cnt_old_neg (ptr[WORD_W-1]),
      .cnt_new_neg (half_sum[1][HALF_W-1]),
      .cnt_cout    (half_cout[1]),
      .trap        (trap)
   );

   logic unused_bits;
   assign unused_bits = word_cout ^ half_cout[0];

   always_comb begin
      nxt  = long_fmt ? word_sum : short_nxt;
      rd   = (op == SP_POP);
      wr   = (op == SP_PUSH);
      unique case (op)
         SP_PUSH: addr = long_fmt ? word_sum : {{HALF_W{1'b0}}, half_sum[0]};
         SP_POP:  addr = long_fmt ? ptr : {{HALF_W{1'b0}}, ptr[HALF_W-1:0]};
         default: addr = '0;
      endcase
   end
endmodule

// File: rtl/sp_out_stage.sv
module sp_out_stage #(
   parameter int WORD_W  = 36,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_ptr,
   input  logic [WORD_W-1:0] in_addr,
   input  logic              in_rd,
   input  logic              in_wr,
   input  logic              in_trap,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_ptr,
   output logic [WORD_W-1:0] out_addr,
   output logic              out_rd,
   output logic              out_wr,
   output logic              out_trap
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_ptr   <= '0;
               out_addr  <= '0;
               out_rd    <= 1'b0;
               out_wr    <= 1'b0;
               out_trap  <= 1'b0;
            end else begin
               out_valid <= in_valid;
               out_rd    <= in_valid & in_rd;
               out_wr    <= in_valid & in_wr;
               out_trap  <= in_valid & in_trap;
               if (in_valid) begin
                  out_ptr  <= in_ptr;
                  out_addr <= in_addr;
               end
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign out_valid  = in_valid;
         assign out_ptr    = in_ptr;
         assign out_addr   = in_valid ? in_addr : '0;
         assign out_rd     = in_valid & in_rd;
         assign out_wr     = in_valid & in_wr;
         assign out_trap   = in_valid & in_trap;
      end
   endgenerate
endmodule

// File: rtl/paired_sp_unit.sv
module paired_sp_unit
   import sp_pkg::*;
#(
   parameter int HALF_W  = 18,
   parameter bit OUT_REG = 1'b1,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op,
   input  logic              long_fmt,
   input  logic [WORD_W-1:0] ptr_in,
   input  logic [HALF_W-1:0] adj,
   output logic              res_valid,
   output logic [WORD_W-1:0] ptr_out,
   output logic [WORD_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              trap
);
   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("paired_sp_unit: HALF_W must be at least 2");
      end
   endgenerate

   sp_op_e            op_e;
   logic              accept;
   logic [WORD_W-1:0] nxt_ptr;
   logic [WORD_W-1:0] nxt_addr;
   logic              nxt_rd;
   logic              nxt_wr;
   logic              nxt_trap;

   assign op_e   = sp_op_e'(op);
   assign accept = op_valid && (op_e != SP_NONE);

   sp_next_ptr #(.HALF_W(HALF_W)) u_next (
      .op       (op_e),
      .long_fmt (long_fmt),
      .ptr      (ptr_in),
      .adj      (adj),
      .nxt      (nxt_ptr),
      .addr     (nxt_addr),
      .rd       (nxt_rd),
      .wr       (nxt_wr),
      .trap     (nxt_trap)
   );

   sp_out_stage #(.WORD_W(WORD_W), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (accept),
      .in_ptr    (nxt_ptr),
      .in_addr   (nxt_addr),
      .in_rd     (nxt_rd),
      .in_wr     (nxt_wr),
      .in_trap   (nxt_trap),
      .out_valid (res_valid),
      .out_ptr   (ptr_out),
      .out_addr  (mem_addr),
      .out_rd    (mem_rd),
      .out_wr    (mem_wr),
      .out_trap  (trap)
   );
endmodule

// File: rtl/paired_sp_unit_chk.sv
module paired_sp_unit_chk #(
   parameter int HALF_W  = 18,
   parameter bit OUT_REG = 1'b1,
   localparam int WORD_W = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [1:0]        op,
   input logic              long_fmt,
   input logic [WORD_W-1:0] ptr_in,
   input logic [HALF_W-1:0] adj,
   input logic              res_valid,
   input logic [WORD_W-1:0] ptr_out,
   input logic [WORD_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              trap
);
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));  // R1

   AST_TRAP_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> res_valid);  // R9

   generate
      if (OUT_REG) begin : g_seq
         AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op != 2'b00) |=> res_valid);  // R1

         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !(op_valid && op != 2'b00) |=> (!res_valid && !trap));  // R1

         AST_PUSH_WRITES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == 2'b01 && !long_fmt) |=>
               (mem_wr && mem_addr == {{HALF_W{1'b0}}, ptr_out[HALF_W-1:0]}));  // R2

         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == 2'b01 && !long_fmt && ptr_in[WORD_W-1:HALF_W] != '1)
               |=> !trap);  // R3

         AST_POP_READS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == 2'b10 && !long_fmt) |=>
               (mem_rd && mem_addr == {{HALF_W{1'b0}}, $past(ptr_in[HALF_W-1:0])}));  // R4

         AST_LONG_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && long_fmt) |=> !trap);  // R8
      end else begin : g_comb
         AST_PUSH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == 2'b01) |-> mem_wr);  // R2
      end
   endgenerate
endmodule

bind paired_sp_unit paired_sp_unit_chk #(.HALF_W(HALF_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op        (op),
   .long_fmt  (long_fmt),
   .ptr_in    (ptr_in),
   .adj       (adj),
   .res_valid (res_valid),
   .ptr_out   (ptr_out),
   .mem_addr  (mem_addr),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .trap      (trap)
);

// File: tb/paired_sp_unit_test.sv
module paired_sp_unit_test;
   localparam int HW = 18;
   localparam int WW = 2 * HW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [1:0]    op = 2'b00;
   logic          long_fmt = 1'b0;
   logic [WW-1:0] ptr_in = '0;
   logic [HW-1:0] adj = '0;
   logic          res_valid;
   logic [WW-1:0] ptr_out;
   logic [WW-1:0] mem_addr;
   logic          mem_rd;
   logic          mem_wr;
   logic          trap;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   typedef struct {
      logic [WW-1:0] ptr;
      logic [WW-1:0] addr;
      logic          rd;
      logic          wr;
      logic          trap;
      string         tag;
   } exp_t;

   exp_t sb[$];

   paired_sp_unit #(.HALF_W(HW), .OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .long_fmt(long_fmt),
      .ptr_in(ptr_in), .adj(adj), .res_valid(res_valid), .ptr_out(ptr_out),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .trap(trap)
   );

   always #5 clk = ~clk;

   function automatic exp_t model(input logic [1:0] o, input logic lf,
                                  input logic [WW-1:0] p, input logic [HW-1:0] a,
                                  input string tag);
      exp_t e;
      logic [HW-1:0] l, r, nl, nr;
      logic [WW-1:0] sx;
      l = p[WW-1:HW];
      r = p[HW-1:0];
      e.tag = tag; e.trap = 1'b0; e.rd = (o == 2'b10); e.wr = (o == 2'b01);
      e.addr = '0;
      if (lf) begin
         sx = {{HW{a[HW-1]}}, a};
         if (o == 2'b01) begin e.ptr = p + 1; e.addr = p + 1; end
         else if (o == 2'b10) begin e.ptr = p - 1; e.addr = p; end
         else e.ptr = p + sx;
      end else begin
         if (o == 2'b01) begin
            nl = l + 1; nr = r + 1;
            e.trap = (l == '1);
            e.addr = {{HW{1'b0}}, nr};
         end else if (o == 2'b10) begin
            nl = l - 1; nr = r - 1;
            e.trap = (l == '0);
            e.addr = {{HW{1'b0}}, r};
         end else begin
            nl = l + a; nr = r + a;
            e.trap = a[HW-1] ? (!l[HW-1] && nl[HW-1]) : (l[HW-1] && !nl[HW-1]);
         end
         e.ptr = {nl, nr};
      end
      return e;
   endfunction

   task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic issue(input logic [1:0] o, input logic lf, input logic [WW-1:0] p,
                        input logic [HW-1:0] a, input string tag);
      @(negedge clk);
      op_valid = 1'b1; op = o; long_fmt = lf; ptr_in = p; adj = a;
      sb.push_back(model(o, lf, p, a, tag));
   endtask

   task automatic idle(input logic v, input logic [1:0] o, input string tag);
      @(negedge clk);
      op_valid = v; op = o; long_fmt = 1'b0; ptr_in = 36'hFFFFF_FFFF; adj = 18'h1;
      @(negedge clk);
      op_valid = 1'b0; op = 2'b00;
      check({tag, " res_valid"}, WW'(res_valid), '0);
      check({tag, " strobes/trap"}, WW'({mem_rd, mem_wr, trap}), '0);
   endtask

   // monitor: pop the oldest expected item whenever a result appears
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R1: actual unexpected result expected none");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " ptr"}, ptr_out, e.ptr);
            check({e.tag, " addr"}, mem_addr, e.addr);
            check({e.tag, " rd/wr"}, WW'({mem_rd, mem_wr}), WW'({e.rd, e.wr}));
            check({e.tag, " trap"}, WW'(trap), WW'(e.trap));
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset outputs", WW'({res_valid, mem_rd, mem_wr, trap}), '0);
      check("R9 reset ptr", ptr_out, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 short push, plain and lower-half wrap
      issue(2'b01, 1'b0, {18'h3FFFA, 18'h01000}, '0, "R2 push");
      issue(2'b01, 1'b0, {18'h00005, 18'h3FFFF}, '0, "R2 push low wrap");
      // R3 count-half carry
      issue(2'b01, 1'b0, {18'h3FFFF, 18'h00010}, '0, "R3 push overflow");
      // R9 trap does not persist into the next result
      issue(2'b01, 1'b0, {18'h00000, 18'h00010}, '0, "R9 pulse clear");
      // R4 short pop, plain and lower-half wrap
      issue(2'b10, 1'b0, {18'h00007, 18'h00200}, '0, "R4 pop");
      issue(2'b10, 1'b0, {18'h00003, 18'h00000}, '0, "R4 pop low wrap");
      // R5 underflow
      issue(2'b10, 1'b0, {18'h00000, 18'h00040}, '0, "R5 pop underflow");
      // R6 adjust, independent halves
      issue(2'b11, 1'b0, {18'h00001, 18'h3FFFE}, 18'h00004, "R6 adjust no cross carry");
      issue(2'b11, 1'b0, {18'h00020, 18'h00100}, 18'h00000, "R6 adjust zero");
      // R7 sign-chosen trap
      issue(2'b11, 1'b0, {18'h3FFFD, 18'h00100}, 18'h00002, "R7 pos stays neg");
      issue(2'b11, 1'b0, {18'h3FFFD, 18'h00100}, 18'h00005, "R7 pos neg-to-nonneg");
      issue(2'b11, 1'b0, {18'h00002, 18'h00100}, 18'h3FFFD, "R7 neg nonneg-to-neg");
      issue(2'b11, 1'b0, {18'h00005, 18'h00100}, 18'h3FFFE, "R7 neg stays nonneg");
      issue(2'b11, 1'b0, {18'h1FFFF, 18'h00100}, 18'h00001, "R7 pos wrap to neg");
      // R8 long format
      issue(2'b01, 1'b1, 36'h0_0003_FFFF, '0, "R8 long push cross half");
      issue(2'b01, 1'b1, 36'hF_FFFF_FFFF, '0, "R8 long push wrap");
      issue(2'b10, 1'b1, 36'h0_0004_0000, '0, "R8 long pop");
      issue(2'b10, 1'b1, 36'h0_0000_0000, '0, "R8 long pop wrap");
      issue(2'b11, 1'b1, 36'h0_0010_0000, 18'h3FFF0, "R8 long adjust neg");
      issue(2'b11, 1'b1, 36'h7_FFFF_FFF0, 18'h00020, "R8 long adjust pos");

      // R1 ignored operations
      idle(1'b1, 2'b00, "R1 op none");
      idle(1'b0, 2'b01, "R1 valid low");
      repeat (2) @(negedge clk);
      check("R1 scoreboard drained", WW'(sb.size()), '0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule